// File: doc/BRIEF.md
# Frame Line Sequencer

This block produces the vertical timing of one frame for an image sensor that is scanned line by line. A horizontal timer supplies a one-cycle tick at the start of each line period. Every sequencer output changes only on that tick, so each output level lasts exactly one line period. After a start command the block first exposes the array. Its integrate output stays high for a programmed number of line periods. It then walks through the 1306 physical lines of the array. For each line it drives a line-clock pulse, an even/odd toggle, a two-line read-start pulse and a 2-bit tag. The tag tells downstream pixel logic what kind of line is being read.

Two readout modes exist. Full resolution reads every line. Half subsampling always reads the black reference lines. Beyond them it reads one line pair and steps over the next, alternating. A skipped pair still gets its two line-clock pulses and one even pulse, but its lines are marked not valid. A shutter option keeps the integrate output high across the whole integrate and read cycle. The integration length, the mode and the shutter option are captured when a frame begins. An active-low synchronous clear abandons a frame at once.

Top module: `frame_line_seq`

## Requirements
- R1: After reset, or while no frame runs, lck_o, integ_o, rd_start_o, even_o, line_vld_o and frame_done_o are 0 and line_tag_o is 00.
- R2: A start pulse while idle is held until the next line tick, which opens the frame. From then on, each line tick of the frame gives one cycle of lck_o in the following cycle. A start while a frame runs is ignored.
- R3: integ_o goes high at the line tick that opens the frame and stays high for exactly int_lines_i line periods; a value of 0 counts as 1. Readout starts on the next tick, where integ_o falls unless shutter is selected.
- R4: rd_start_o is high for exactly the first two readout line periods, and it rises together with even_o.
- R5: During readout even_o is 1 on even physical lines (0, 2, ...) and 0 on odd ones, so it toggles every line period. It is 0 during integration.
- R6: line_tag_o encodes 00 black, 01 characterisation, 10 dummy and 11 video. In full mode the physical lines in order are 6 black, 8 characterisation, 2 dummy, 1280 video, 2 dummy and 8 characterisation, all valid, 1306 in total.
- R7: In half mode (half_i=1 at start) the 6 black lines are valid. After them, pairs alternate between read and skipped, starting with read. This gives 4 characterisation, 2 dummy, 640 video and 4 characterisation valid lines. Skipped lines have line_vld_o=0 but keep their lck_o and even_o.
- R8: With shutter_i=1 at start, integ_o stays high through the last readout line and falls with the end of the frame.
- R9: The line tick after the last line puts frame_done_o high for one cycle and returns the block to idle with all pulses low.
- R10: clr_ni low at a clock edge returns the block to idle with all outputs low and discards a pending start.
- R11: int_lines_i, half_i and shutter_i are sampled only at the tick that opens a frame. Changing them later has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_ni | input | 1 | Synchronous active-low clear to idle |
| line_tick_i | input | 1 | One-cycle tick marking each line period |
| start_i | input | 1 | Start-of-frame command |
| int_lines_i | input | INT_W | Integration length in line periods |
| half_i | input | 1 | Half vertical subsampling select |
| shutter_i | input | 1 | Hold integrate high through readout |
| lck_o | output | 1 | Line clock pulse, one cycle per line period |
| integ_o | output | 1 | Integrate pulse |
| rd_start_o | output | 1 | Two-line read-start pulse |
| even_o | output | 1 | Even/odd line toggle |
| line_tag_o | output | 2 | Line type of the current line |
| line_vld_o | output | 1 | Current line is read (not skipped) |
| frame_done_o | output | 1 | One-cycle pulse after the last line |

## Verification
The assertions assume that line ticks are single-cycle pulses with idle cycles between them. The even-toggle check also assumes that the line clock never carries two ticks back to back. The bench's tick generator fires once every four cycles. Start, clear and the configuration inputs are changed only between clock edges, half a cycle away from the active edge. A behavioural model sees the same inputs, and its per-line outputs are compared every cycle. Per-frame tallies of valid lines by tag, of read-start lines and of integrate lines check the sequence totals.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [1:0] {
    LT_BLACK = 2'b00,
    LT_CHAR  = 2'b01,
    LT_DUMMY = 2'b10,
    LT_VIDEO = 2'b11
  } line_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_READ  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fls_line_map.sv
module fls_line_map
  import fls_pkg::*;
#(
  parameter int N_BLACK = 6,
  parameter int N_CHAR  = 8,
  parameter int N_DUMMY = 2,
  parameter int N_VIDEO = 1280,
  parameter int P_W     = 11
) (
  input  logic [P_W-1:0] pos_i,
  input  logic           half_i,
  output line_kind_e     kind_o,
  output logic           keep_o
);
  localparam int E_BLK = N_BLACK;
  localparam int E_CH1 = E_BLK + N_CHAR;
  localparam int E_DM1 = E_CH1 + N_DUMMY;
  localparam int E_VID = E_DM1 + N_VIDEO;
  localparam int E_DM2 = E_VID + N_DUMMY;

  logic [P_W-1:0] rel;

  always_comb begin
    if (pos_i < P_W'(E_BLK))      kind_o = LT_BLACK;
    else if (pos_i < P_W'(E_CH1)) kind_o = LT_CHAR;
    else if (pos_i < P_W'(E_DM1)) kind_o = LT_DUMMY;
    else if (pos_i < P_W'(E_VID)) kind_o = LT_VIDEO;
    else if (pos_i < P_W'(E_DM2)) kind_o = LT_DUMMY;
    else                          kind_o = LT_CHAR;
  end

  // pairs beyond the black lines alternate read / skipped in half mode
  assign rel    = pos_i - P_W'(E_BLK);
  assign keep_o = !half_i || (pos_i < P_W'(E_BLK)) || !rel[1];
endmodule

// File: rtl/fls_ctrl.sv
module fls_ctrl
  import fls_pkg::*;
#(
  parameter int TOTAL = 1306,
  parameter int INT_W = 16,
  parameter int P_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_ni,
  input  logic             line_tick_i,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_lines_i,
  input  logic             half_i,
  input  logic             shutter_i,
  output logic [P_W-1:0]   pos_nxt_o,
  output logic             half_nxt_o,
  input  line_kind_e       kind_i,
  input  logic             keep_i,
  output logic             lck_o,
  output logic             integ_o,
  output logic             rd_start_o,
  output logic             even_o,
  output logic [1:0]       line_tag_o,
  output logic             line_vld_o,
  output logic             frame_done_o
);
  localparam logic [P_W-1:0] LAST = P_W'(TOTAL - 1);

  seq_state_e       state_q, state_n;
  logic [INT_W-1:0] left_q, left_n;
  logic [P_W-1:0]   pos_q, pos_n;
  logic             half_q, half_n, shut_q, shut_n, pend_q, pend_n, ending;

  always_comb begin
    state_n = state_q;
    left_n  = left_q;
    pos_n   = pos_q;
    half_n  = half_q;
    shut_n  = shut_q;
    pend_n  = pend_q;
    ending  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (line_tick_i && (pend_q || start_i)) begin
          state_n = ST_INTEG;
          left_n  = (int_lines_i == '0) ? '0 : int_lines_i - INT_W'(1);
          half_n  = half_i;
          shut_n  = shutter_i;
          pend_n  = 1'b0;
        end else if (start_i) begin
          pend_n = 1'b1;
        end
      end
      ST_INTEG: if (line_tick_i) begin
        if (left_q == '0) begin
          state_n = ST_READ;
          pos_n   = '0;
        end else begin
          left_n = left_q - INT_W'(1);
        end
      end
      default: if (line_tick_i) begin
        if (pos_q == LAST) begin
          state_n = ST_IDLE;
          ending  = 1'b1;
        end else begin
          pos_n = pos_q + P_W'(1);
        end
      end
    endcase
  end

  assign pos_nxt_o  = pos_n;
  assign half_nxt_o = half_n;

  always_ff @(posedge clk) begin
    if (rst || !clr_ni) begin
      state_q      <= ST_IDLE;
      left_q       <= '0;
      pos_q        <= '0;
      half_q       <= 1'b0;
      shut_q       <= 1'b0;
      pend_q       <= 1'b0;
      lck_o        <= 1'b0;
      integ_o      <= 1'b0;
      rd_start_o   <= 1'b0;
      even_o       <= 1'b0;
      line_tag_o   <= LT_BLACK;
      line_vld_o   <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      state_q      <= state_n;
      left_q       <= left_n;
      pos_q        <= pos_n;
      half_q       <= half_n;
      shut_q       <= shut_n;
      pend_q       <= pend_n;
      lck_o        <= line_tick_i && (state_n != ST_IDLE);
      frame_done_o <= ending;
      if (line_tick_i) begin
        integ_o    <= (state_n == ST_INTEG) || ((state_n == ST_READ) && shut_n);
        rd_start_o <= (state_n == ST_READ) && (pos_n < P_W'(2));
        even_o     <= (state_n == ST_READ) && !pos_n[0];
        line_tag_o <= (state_n == ST_READ) ? kind_i : LT_BLACK;
        line_vld_o <= (state_n == ST_READ) && keep_i;
      end
    end
  end

  AST_RD_RISES_WITH_EVEN: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_start_o) |-> even_o); // R4
  AST_RD_AFTER_INTEG: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_start_o) |-> $past(integ_o)); // R3
  AST_EVEN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(even_o) |-> ($past(line_tick_i) || $past(!clr_ni))); // R5
  AST_LCK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    lck_o |-> (state_q != ST_IDLE)); // R2
  AST_BLACK_KEPT: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_READ) && (line_tag_o == LT_BLACK)) |-> line_vld_o); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> (!integ_o && !rd_start_o && !line_vld_o && !lck_o)); // R9
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!clr_ni) |-> (!integ_o && !rd_start_o && !lck_o && !frame_done_o)); // R10
endmodule

// File: rtl/frame_line_seq.sv
module frame_line_seq
  import fls_pkg::*;
#(
  parameter int N_BLACK = 6,
  parameter int N_CHAR  = 8,
  parameter int N_DUMMY = 2,
  parameter int N_VIDEO = 1280,
  parameter int INT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_ni,
  input  logic             line_tick_i,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_lines_i,
  input  logic             half_i,
  input  logic             shutter_i,
  output logic             lck_o,
  output logic             integ_o,
  output logic             rd_start_o,
  output logic             even_o,
  output logic [1:0]       line_tag_o,
  output logic             line_vld_o,
  output logic             frame_done_o
);
  localparam int TOTAL = N_BLACK + 2 * N_CHAR + 2 * N_DUMMY + N_VIDEO;
  localparam int P_W   = $clog2(TOTAL);

  logic [P_W-1:0] pos_nxt;
  logic           half_nxt, keep;
  line_kind_e     kind;

  fls_line_map #(
    .N_BLACK(N_BLACK), .N_CHAR(N_CHAR), .N_DUMMY(N_DUMMY),
    .N_VIDEO(N_VIDEO), .P_W(P_W)
  ) i_map (
    .pos_i(pos_nxt), .half_i(half_nxt), .kind_o(kind), .keep_o(keep)
  );

  fls_ctrl #(.TOTAL(TOTAL), .INT_W(INT_W), .P_W(P_W)) i_ctrl (
    .clk(clk), .rst(rst), .clr_ni(clr_ni), .line_tick_i(line_tick_i),
    .start_i(start_i), .int_lines_i(int_lines_i), .half_i(half_i),
    .shutter_i(shutter_i), .pos_nxt_o(pos_nxt), .half_nxt_o(half_nxt),
    .kind_i(kind), .keep_i(keep), .lck_o(lck_o), .integ_o(integ_o),
    .rd_start_o(rd_start_o), .even_o(even_o), .line_tag_o(line_tag_o),
    .line_vld_o(line_vld_o), .frame_done_o(frame_done_o)
  );
endmodule

// File: tb/test_frame_line_seq.sv
`timescale 1ns/1ps
module test_frame_line_seq;
  localparam int TOTAL = 1306;

  logic clk = 0, rst = 1, clr_n = 1, tick = 0, start = 0, half = 0, shut = 0;
  logic [15:0] nint = 16'd3;
  logic lck, integ, rd, even, vld, done;
  logic [1:0] tag;

  int tests = 0, fails = 0, cyc = 0, tcnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_line_seq i_frame_line_seq (
    .clk(clk), .rst(rst), .clr_ni(clr_n), .line_tick_i(tick), .start_i(start),
    .int_lines_i(nint), .half_i(half), .shutter_i(shut), .lck_o(lck),
    .integ_o(integ), .rd_start_o(rd), .even_o(even), .line_tag_o(tag),
    .line_vld_o(vld), .frame_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int tag_of(input int p);
    if (p < 6) return 0;
    if (p < 14) return 1;
    if (p < 16) return 2;
    if (p < 1296) return 3;
    if (p < 1298) return 2;
    return 1;
  endfunction

  function automatic bit keep_of(input int p, input bit h);
    return !h || p < 6 || (((p - 6) / 2) % 2 == 0);
  endfunction

  // tick generator: one cycle in four
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  // behavioural reference model
  int  m_st = 0, m_left = 0, m_pos = 0;
  bit  m_half = 0, m_shut = 0, m_pend = 0;
  bit  e_lck = 0, e_integ = 0, e_rd = 0, e_even = 0, e_vld = 0, e_done = 0;
  int  e_tag = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst || !clr_n) begin
      m_st = 0; m_pend = 0;
      e_lck = 0; e_integ = 0; e_rd = 0; e_even = 0; e_vld = 0; e_done = 0; e_tag = 0;
    end else begin
      e_lck = 0; e_done = 0;
      if (m_st == 0) begin
        if (tick && (m_pend || start)) begin
          m_st = 1; m_left = (nint == 0) ? 0 : int'(nint) - 1;
          m_half = half; m_shut = shut; m_pend = 0;
        end else if (start) m_pend = 1;
      end else if (tick) begin
        if (m_st == 1) begin
          if (m_left == 0) begin m_st = 2; m_pos = 0; end
          else m_left--;
        end else begin
          if (m_pos == TOTAL - 1) begin m_st = 0; e_done = 1; end
          else m_pos++;
        end
      end
      if (tick) begin
        e_lck   = (m_st != 0);
        e_integ = (m_st == 1) || (m_st == 2 && m_shut);
        e_rd    = (m_st == 2) && (m_pos < 2);
        e_even  = (m_st == 2) && (m_pos % 2 == 0);
        e_tag   = (m_st == 2) ? tag_of(m_pos) : 0;
        e_vld   = (m_st == 2) && keep_of(m_pos, m_half);
      end
    end
  end

  // per-frame tallies
  int  cnt[4];
  int  rd_lines = 0, int_lines = 0, f_int = 1;
  bit  seen_rd = 0, f_half = 0, compare_on = 0;

  task automatic frame_clear_counts(input int n, input bit h);
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    rd_lines = 0; int_lines = 0; seen_rd = 0;
    f_int = (n == 0) ? 1 : n; f_half = h;
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk(lck == e_lck, "R2 lck", lck, e_lck);
      chk(integ == e_integ, "R3/R8 integ", integ, e_integ);
      chk(rd == e_rd, "R4 rd_start", rd, e_rd);
      chk(even == e_even, "R5 even", even, e_even);
      chk(int'(tag) == e_tag, "R6 tag", tag, e_tag);
      chk(vld == e_vld, "R7 line_vld", vld, e_vld);
      chk(done == e_done, "R9 frame_done", done, e_done);
    end
    if (lck) begin
      if (rd) begin rd_lines++; seen_rd = 1; end
      if (integ && !seen_rd) int_lines++;
      if (vld) cnt[tag]++;
    end
    if (done) begin
      chk(cnt[0] == 6, "R6 black count", cnt[0], 6);
      chk(cnt[1] == (f_half ? 8 : 16), "R7 char count", cnt[1], f_half ? 8 : 16);
      chk(cnt[2] == (f_half ? 2 : 4), "R7 dummy count", cnt[2], f_half ? 2 : 4);
      chk(cnt[3] == (f_half ? 640 : 1280), "R6 video count", cnt[3], f_half ? 640 : 1280);
      chk(rd_lines == 2, "R4 read lines", rd_lines, 2);
      chk(int_lines == f_int, "R3 integ lines", int_lines, f_int);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, "R9 frame end seen", done, 1);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({lck, integ, rd, even, vld, done} == 6'b0, "R1 reset outputs",
        {lck, integ, rd, even, vld, done}, 0);
    chk(tag == 2'b00, "R1 reset tag", tag, 0);
    repeat (10) @(negedge clk);
    chk(!lck && !integ, "R1 idle quiet", lck, 0);
    compare_on = 1;

    // full resolution, 3 integrate lines
    frame_clear_counts(3, 0);
    nint = 3; half = 0; shut = 0;
    pulse_start();
    wait_done();

    // half mode, zero integration; mid-frame start and config change (R2, R11)
    frame_clear_counts(0, 1);
    nint = 0; half = 1; shut = 0;
    pulse_start();
    repeat (40) @(negedge clk);
    nint = 9; half = 0; shut = 1;
    pulse_start();
    wait_done();
    repeat (20) @(negedge clk);
    chk(!lck, "R2 busy start ignored", lck, 0);

    // shutter, full mode, 5 integrate lines (R8)
    frame_clear_counts(5, 0);
    nint = 5; half = 0; shut = 1;
    pulse_start();
    wait_done();

    // clear mid readout (R10)
    nint = 2; half = 1; shut = 1;
    pulse_start();
    repeat (200) @(negedge clk);
    clr_n = 0;
    @(negedge clk);
    clr_n = 1;
    chk(!integ && !rd && !lck && !vld, "R10 cleared outputs", integ, 0);
    repeat (60) @(negedge clk);
    chk(!integ && !lck, "R10 stays idle", integ, 0);

    // pending start discarded by clear (R10)
    @(negedge clk); while (tick) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    clr_n = 0; @(negedge clk); clr_n = 1;
    repeat (20) @(negedge clk);
    chk(!integ, "R10 pending start dropped", integ, 0);

    // half mode after clear, with shutter
    frame_clear_counts(2, 1);
    nint = 2; half = 1; shut = 1;
    pulse_start();
    wait_done();
    repeat (8) @(negedge clk);
    chk(!integ && !lck, "R9 idle after frame", integ, 0);
    summary();
  end
endmodule